// File: doc/BRIEF.md
# Segmented memory address generator

This block turns a 16-bit segment base and a 16-bit offset into a 20-bit physical address in a 1 MB space. It holds four segment bases: code, data, stack and extra. A requester names only the kind of access it wants. The block then picks the matching base, adds the offset to the base shifted left by four bits, and drops any carry out of bit 19. The address appears on a registered output together with a one-cycle valid pulse.

The block also keeps its own 16-bit stack offset, so push and pop requests need no offset from outside. A push moves the offset down by two and then addresses the new location. A pop addresses the current location and then moves the offset up by two. Segments are purely logical. They may overlap freely, and nothing checks for overlap.

A two-state machine drives the output. In `S_IDLE`, no address is being presented and the valid output is low. In `S_ISSUE`, the address captured at the last edge is presented with valid high. From either state, an accepted operation (push, pop or request) leads to `S_ISSUE` at the next edge. A cycle with no operation leads to `S_IDLE`. Reset leads to `S_IDLE`.

Top module: `seg_addr_gen`

## Requirements
- R1: The output address equals (segment base × 16 + offset) modulo 2^20. It appears on `addr_out` one clock after the operation is presented, together with `addr_valid` high.
- R2: `req_type` selects the base: 0 = fetch (code), 1 = data, 2 = stack, 3 = extra. `seg_sel` uses the same codes to pick the segment register written.
- R3: A segment write takes effect at the clock edge. A request in the same cycle as a write to its segment uses the old base. The next cycle uses the new base.
- R4: After reset, the code base is 0xFFFF and the data, stack and extra bases are 0. The stack offset is 0, `addr_valid` is low and `addr_out` is 0. A fetch at offset 0 therefore yields 0xFFFF0.
- R5: A push first lowers the stack offset by 2 and then addresses (stack base × 16 + new offset).
- R6: A pop addresses (stack base × 16 + current offset) and then raises the stack offset by 2. A push followed at once by a pop gives the same address for both.
- R7: Stack offset arithmetic wraps modulo 65536. A push from offset 0 uses offset 0xFFFE.
- R8: Push has priority over pop, and pop has priority over `req_valid`. Only the winning operation is performed. The losing ones have no effect on the address or on the stack offset.
- R9: In a cycle with no push, pop or request, `addr_valid` is low one clock later and `addr_out` keeps its value.
- R10: Carries past bit 19 are discarded. For example, code base 0xFFFF with offset 0xFFFF gives 0x0FFEF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_we | input | 1 | Segment register write enable |
| seg_sel | input | 2 | Segment register written (0 code, 1 data, 2 stack, 3 extra) |
| seg_wdata | input | 16 | New segment base |
| req_valid | input | 1 | Explicit access request |
| req_type | input | 2 | Access kind (0 fetch, 1 data, 2 stack, 3 extra) |
| req_offset | input | 16 | Offset for an explicit request |
| push | input | 1 | Stack push strobe |
| pop | input | 1 | Stack pop strobe |
| addr_out | output | 20 | Registered physical address |
| addr_valid | output | 1 | One-cycle pulse, high while `addr_out` holds a new address |

## Verification
Every operation presented in a cycle gives its result exactly one edge later. This holds for requests, pushes and pops alike. A segment write, by contrast, shows up only in the address of an operation issued in a later cycle. The bench drives one item per cycle at the falling edge and queues the expected valid flag and address for every cycle, idle cycles included. The monitor then pops one entry per rising edge, 2 ns after the edge. This keeps each comparison on the cycle where the single output register has just been loaded. Back-to-back push/pop pairs and write-then-use pairs are placed in adjacent cycles, so a result that arrives one cycle late or early shows up as a mismatch.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
    localparam int SEG_W   = 16;
    localparam int OFF_W   = 16;
    localparam int SHIFT   = 4;
    localparam int ADDR_W  = SEG_W + SHIFT;
    localparam int NUM_SEG = 4;
    localparam int SEL_W   = $clog2(NUM_SEG);
    localparam int STEP    = 2;

    localparam logic [SEL_W-1:0] SEG_CODE  = 2'd0;
    localparam logic [SEL_W-1:0] SEG_DATA  = 2'd1;
    localparam logic [SEL_W-1:0] SEG_STACK = 2'd2;
    localparam logic [SEL_W-1:0] SEG_EXTRA = 2'd3;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_ISSUE = 1'b1
    } issue_state_t;
endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
    parameter int DW        = 16,
    parameter int NSEG      = 4,
    parameter int SW        = 2,
    parameter int CODE_IDX  = 0,
    parameter logic [DW-1:0] CODE_RST = '1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [SW-1:0]          sel,
    input  logic [DW-1:0]          wdata,
    output logic [NSEG-1:0][DW-1:0] bases
);
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        localparam logic [DW-1:0] RST_VAL = (g == CODE_IDX) ? CODE_RST : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bases[g] <= RST_VAL;
            else if (we && (sel == SW'(g)))
                bases[g] <= wdata;
        end
    end
endmodule

// File: rtl/stack_ptr.sv
module stack_ptr #(
    parameter int DW   = 16,
    parameter int STEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_push,
    input  logic          do_pop,
    output logic [DW-1:0] sp_q,
    output logic [DW-1:0] sp_dec
);
    localparam logic [DW-1:0] STEP_V = DW'(STEP);

    logic [DW-1:0] sp_inc;

    always_comb begin
        sp_dec = sp_q - STEP_V;
        sp_inc = sp_q + STEP_V;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sp_q <= '0;
        else if (do_push)
            sp_q <= sp_dec;
        else if (do_pop)
            sp_q <= sp_inc;
    end
endmodule

// File: rtl/phys_adder.sv
module phys_adder #(
    parameter int SEGW  = 16,
    parameter int OFFW  = 16,
    parameter int SHIFT = 4,
    parameter int AW    = SEGW + SHIFT
) (
    input  logic [SEGW-1:0] base,
    input  logic [OFFW-1:0] offset,
    output logic [AW-1:0]   addr
);
    localparam int SUM_W = ((SEGW + SHIFT) > OFFW ? (SEGW + SHIFT) : OFFW) + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum  = SUM_W'({base, {SHIFT{1'b0}}}) + SUM_W'(offset);
        addr = sum[AW-1:0];
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_we,
    input  logic [SEL_W-1:0]  seg_sel,
    input  logic [SEG_W-1:0]  seg_wdata,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_type,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic              push,
    input  logic              pop,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_valid
);
    logic [NUM_SEG-1:0][SEG_W-1:0] bases;
    logic [OFF_W-1:0]  sp_q, sp_dec;
    logic              do_push, do_pop, do_req, accept;
    logic [SEG_W-1:0]  sel_base;
    logic [OFF_W-1:0]  sel_off;
    logic [ADDR_W-1:0] phys;
    issue_state_t      state_q, state_d;
    logic [ADDR_W-1:0] addr_q;

    seg_bank #(
        .DW(SEG_W), .NSEG(NUM_SEG), .SW(SEL_W),
        .CODE_IDX(int'(SEG_CODE)), .CODE_RST('1)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .we(seg_we),
        .sel(seg_sel), .wdata(seg_wdata), .bases(bases)
    );

    stack_ptr #(.DW(OFF_W), .STEP(STEP)) u_sp (
        .clk(clk), .rst_n(rst_n),
        .do_push(do_push), .do_pop(do_pop),
        .sp_q(sp_q), .sp_dec(sp_dec)
    );

    phys_adder #(.SEGW(SEG_W), .OFFW(OFF_W), .SHIFT(SHIFT), .AW(ADDR_W)) u_add (
        .base(sel_base), .offset(sel_off), .addr(phys)
    );

    // Arbitration: push, then pop, then explicit request.
    always_comb begin
        do_push = push;
        do_pop  = pop & ~push;
        do_req  = req_valid & ~push & ~pop;
        accept  = do_push | do_pop | do_req;
        if (do_push) begin
            sel_base = bases[SEG_STACK];
            sel_off  = sp_dec;
        end else if (do_pop) begin
            sel_base = bases[SEG_STACK];
            sel_off  = sp_q;
        end else begin
            sel_base = bases[req_type];
            sel_off  = req_offset;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = accept ? S_ISSUE : S_IDLE;
            S_ISSUE: state_d = accept ? S_ISSUE : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (accept)
            addr_q <= phys;
    end

    always_comb begin
        addr_out   = addr_q;
        addr_valid = (state_q == S_ISSUE);
    end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk
    import seg_addr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              seg_we,
    input logic [SEL_W-1:0]  seg_sel,
    input logic              req_valid,
    input logic              push,
    input logic              pop,
    input logic [ADDR_W-1:0] addr_out,
    input logic              addr_valid
);
    logic any_op, stk_wr;
    assign any_op = push | pop | req_valid;
    assign stk_wr = seg_we & (seg_sel == SEG_STACK);

    p_valid_after_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
        any_op |=> addr_valid);

    p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !any_op |=> !addr_valid);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !any_op |=> $stable(addr_out));

    p_push_pop_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !stk_wr) ##1 (pop && !push && !stk_wr) |=> addr_out == $past(addr_out));

    p_reset_quiet_r4: assert property (@(posedge clk)
        !rst_n |=> !addr_valid);
endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (.*);

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
    import seg_addr_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seg_we = 1'b0;
    logic [1:0] seg_sel = '0;
    logic [15:0] seg_wdata = '0;
    logic req_valid = 1'b0;
    logic [1:0] req_type = '0;
    logic [15:0] req_offset = '0;
    logic push = 1'b0, pop = 1'b0;
    logic [19:0] addr_out;
    logic addr_valid;

    always #4 clk = ~clk;

    seg_addr_gen u_seg_addr_gen (
        .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_sel(seg_sel),
        .seg_wdata(seg_wdata), .req_valid(req_valid), .req_type(req_type),
        .req_offset(req_offset), .push(push), .pop(pop),
        .addr_out(addr_out), .addr_valid(addr_valid)
    );

    typedef struct {
        logic        v;
        logic [19:0] a;
        int          rq;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, fails = 0;
    logic [15:0] sr_m [4];
    logic [15:0] sp_m;
    logic [19:0] last_m;
    bit done = 0;

    function automatic logic [19:0] phys_m(input logic [15:0] b, input logic [15:0] o);
        return {b, 4'h0} + {4'h0, o};
    endfunction

    task automatic check(input int rq, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Driver: one item per cycle, expected result queued for the next edge.
    task automatic cyc(input logic we, input logic [1:0] sel, input logic [15:0] wd,
                       input logic rv, input logic [1:0] rt, input logic [15:0] ro,
                       input logic ps, input logic pp, input int rq);
        exp_t e;
        @(negedge clk);
        seg_we = we; seg_sel = sel; seg_wdata = wd;
        req_valid = rv; req_type = rt; req_offset = ro;
        push = ps; pop = pp;
        e.v = ps | pp | rv;
        e.rq = rq;
        if (ps) begin
            sp_m = sp_m - 16'd2;
            e.a = phys_m(sr_m[2], sp_m);
        end else if (pp) begin
            e.a = phys_m(sr_m[2], sp_m);
            sp_m = sp_m + 16'd2;
        end else if (rv) begin
            e.a = phys_m(sr_m[rt], ro);
        end else begin
            e.a = last_m;
        end
        last_m = e.a;
        if (we) sr_m[sel] = wd;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int rq);
        cyc(1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b0, rq);
    endtask

    // Monitor: compare one queued entry per rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.rq, {19'h0, addr_valid}, {19'h0, e.v});
                if (e.v || e.rq == 9) check(e.rq, addr_out, e.a);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        sr_m[0] = 16'hFFFF; sr_m[1] = 16'h0; sr_m[2] = 16'h0; sr_m[3] = 16'h0;
        sp_m = 16'h0; last_m = 20'h0;
        repeat (3) @(posedge clk);
        #2;
        // R4: reset state at the ports
        check(4, {19'h0, addr_valid}, 20'h0);
        check(4, addr_out, 20'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R4/R2: first fetch from reset code base
        cyc(1'b0, 2'd0, 16'h0, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 4);
        // R10: wrap past the 1 MB top
        cyc(1'b0, 2'd0, 16'h0, 1'b1, 2'd0, 16'hFFFF, 1'b0, 1'b0, 10);
        // R3: write data base while reading it, old base used
        cyc(1'b1, 2'd1, 16'h1234, 1'b1, 2'd1, 16'h0010, 1'b0, 1'b0, 3);
        // R3/R1: new base visible next cycle
        cyc(1'b0, 2'd0, 16'h0, 1'b1, 2'd1, 16'h0010, 1'b0, 1'b0, 3);
        cyc(1'b1, 2'd3, 16'h2000, 1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 9);
        cyc(1'b1, 2'd2, 16'h3000, 1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 9);
        // R2: extra and stack kinds
        cyc(1'b0, 2'd0, 16'h0, 1'b1, 2'd3, 16'h0005, 1'b0, 1'b0, 2);
        cyc(1'b0, 2'd0, 16'h0, 1'b1, 2'd2, 16'h0100, 1'b0, 1'b0, 2);
        cyc(1'b0, 2'd0, 16'h0, 1'b1, 2'd1, 16'hABCD, 1'b0, 1'b0, 1);
        // R9: idle holds address, valid low
        idle(9);
        idle(9);
        // R5/R7: push from zero wraps to 0xFFFE
        cyc(1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 7);
        cyc(1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 5);
        // R6: pops retrace in reverse
        cyc(1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 6);
        cyc(1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 6);
        // R8: push beats pop and request; pop beats request
        cyc(1'b0, 2'd0, 16'h0, 1'b1, 2'd1, 16'h0044, 1'b1, 1'b1, 8);
        cyc(1'b0, 2'd0, 16'h0, 1'b1, 2'd1, 16'h0044, 1'b0, 1'b1, 8);
        // R8: stack offset back at 0 proves losers did nothing
        cyc(1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 8);
        cyc(1'b0, 2'd0, 16'h0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 6);
        idle(9);
        cyc(1'b0, 2'd0, 16'h0, 1'b1, 2'd0, 16'h0100, 1'b0, 1'b0, 1);
        idle(9);
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule